// File: doc/BRIEF.md
# Orbit Period Monitor with History FIFO

This block sits on one conditioned orbit signal in the bunch-clock domain and keeps three views of it. The first is a running count of orbit pulses. The second is the length, in clock ticks, of the most recent interval between pulses. The third is a history of recent intervals, which a bus master drains one word per access. The orbit input may stay high for several ticks. Only its rising edge marks a pulse.

The pulse count has its own level enable and its own clear strobe. Period measurement also has a level enable and a clear strobe. The period clear restarts the interval timer and empties the history in the same cycle. Every reported interval is one tick longer than the real gap. The first interval after an enable or a clear is timed from that control cycle, not from a pulse, so it carries no meaning about the orbit.

Measurement is run by a two-state machine.
- `PS_IDLE` means measurement is off. It moves to `PS_TIMING` on the transition "arm" when the period enable is sampled high.
- `PS_TIMING` times intervals. It moves back to `PS_IDLE` on the transition "disarm" when the period enable is sampled low.
- In `PS_TIMING`, a pulse or a period clear restarts the timer but keeps the state.

Top module: `orbit_period_mon`

## Requirements
- R1: After reset:
  - the pulse count is 0;
  - the last-period output is 0;
  - the status is 2'b01 (empty);
  - the read word is 0.
- R2: The pulse count rises by one for each rising edge of `orbit_i` that is sampled while `pcnt_en_i` is high. It is visible one cycle after the edge cycle. A pulse that stays high for several cycles counts once. With `pcnt_en_i` low the count holds.
- R3: A cycle with `pcnt_clr_i` high makes the pulse count 0 in the next cycle. This takes priority over a simultaneous edge.
- R4: The pulse count is CNT_W bits wide (default 32) and wraps from all ones to 0.
- R5: The last-period output updates one cycle after each measured edge. Its value is the low LAST_W bits (default 12) of the gap in ticks plus one. The gap is counted from the previous measured edge, or from the latest arm or period-clear cycle if that is later.
- R6: Each measured period (PER_W = 14 bits) is stored in the history, oldest read first. A read strobe updates `rd_word_o` one cycle later:
  - bits 13:0 hold the period;
  - bit 14 is 1 when the word is the last stored entry;
  - when the history is empty the word is 16'h4000;
  - bit 15 is always 0;
  - without a read strobe the word holds.
- R7: `fifo_status_o` bit 0 is 1 when the history is empty and bit 1 is 1 when it holds DEPTH entries (default 256).
- R8: When the history is full, a newly measured period is dropped. The stored entries are left unchanged, but the last-period output still updates.
- R9: A cycle with `per_clr_i` high empties the history (status 2'b01 next cycle). It restarts the interval timer from that cycle. An edge in the same cycle is not stored.
- R10: While `per_en_i` is low, edges neither update the last-period output nor store anything. On re-enable the first gap is timed from the arm cycle.
- R11: The interval timer saturates at 14'h3FFF. A gap longer than that reports 16383, which makes the last-period output 12'hFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Active-low synchronous reset |
| orbit_i | input | 1 | Conditioned orbit signal; rising edge marks a pulse |
| pcnt_en_i | input | 1 | Pulse count enable (level) |
| pcnt_clr_i | input | 1 | Pulse count clear strobe |
| per_en_i | input | 1 | Period measurement enable (level) |
| per_clr_i | input | 1 | Period timer restart and history flush strobe |
| rd_req_i | input | 1 | Read one history word |
| rd_word_o | output | PER_W+2 | Read word: period in bits 13:0, last/empty flag in bit 14 |
| last_period_o | output | LAST_W | Most recent period plus one, low bits |
| pulse_count_o | output | CNT_W | Number of counted pulses |
| fifo_status_o | output | 2 | Bit 1 full, bit 0 empty |

## Verification
The following results are all due one cycle after the clock edge that samples the stimulus:
- the pulse count and the last-period value, after an edge;
- the read word, after a read strobe;
- the flushed status, after a clear.

The bench drives inputs just after a falling edge, so each stimulus is taken at exactly one rising edge, and it samples at the following falling edge. Interval stimulus is built by a task that places each edge an exact number of rising edges after the previous edge or control event. The expected period is therefore the gap plus one, with no extra latency term. Saturation and history-full cases are timed the same way, over thousands of cycles.

// File: rtl/opm_pkg.sv
package opm_pkg;
    typedef enum logic [0:0] {
        PS_IDLE   = 1'b0,
        PS_TIMING = 1'b1
    } per_state_e;
endpackage

// File: rtl/opm_pulse_counter.sv
module opm_pulse_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic             enable_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] count_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (clear_i) begin
            count_o <= '0;
        end else if (enable_i && edge_i) begin
            count_o <= count_o + 1'b1;
        end
    end
endmodule

// File: rtl/opm_period_fsm.sv
module opm_period_fsm
    import opm_pkg::*;
#(
    parameter int PER_W  = 14,
    parameter int LAST_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_i,
    input  logic              enable_i,
    input  logic              restart_i,
    output logic              push_o,
    output logic [PER_W-1:0]  period_o,
    output logic [LAST_W-1:0] last_o
);
    localparam logic [PER_W-1:0] TICK_MAX = {PER_W{1'b1}};

    per_state_e       state_q, state_d;
    logic [PER_W-1:0] tick_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    // transitions: arm / disarm
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE:   if (enable_i)  state_d = PS_TIMING;
            PS_TIMING: if (!enable_i) state_d = PS_IDLE;
            default:   state_d = PS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        period_o = (tick_q == TICK_MAX) ? TICK_MAX : tick_q + 1'b1;
        push_o   = (state_q == PS_TIMING) && enable_i && edge_i && !restart_i;
    end

    // interval timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else begin
            unique case (state_q)
                PS_IDLE: tick_q <= enable_i ? PER_W'(1) : '0;
                PS_TIMING: begin
                    if (!enable_i)                  tick_q <= '0;
                    else if (restart_i || edge_i)   tick_q <= PER_W'(1);
                    else if (tick_q != TICK_MAX)    tick_q <= tick_q + 1'b1;
                end
                default: tick_q <= '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      last_o <= '0;
        else if (push_o) last_o <= period_o[LAST_W-1:0];
    end
endmodule

// File: rtl/opm_history_fifo.sv
module opm_history_fifo #(
    parameter int W     = 14,
    parameter int DEPTH = 256
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         rd_i,
    input  logic         flush_i,
    output logic [W+1:0] rd_word_o,
    output logic         full_o,
    output logic         empty_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;
    logic          do_push, do_pop;

    always_comb begin
        full_o  = (cnt_q == (AW+1)'(DEPTH));
        empty_o = (cnt_q == '0);
        do_push = push_i && !full_o;
        do_pop  = rd_i && !empty_o;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= din_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q      <= '0;
            rp_q      <= '0;
            cnt_q     <= '0;
            rd_word_o <= '0;
        end else begin
            if (rd_i) begin
                if (empty_o) rd_word_o <= {2'b01, {W{1'b0}}};
                else         rd_word_o <= {1'b0, (cnt_q == (AW+1)'(1)), mem[rp_q]};
            end
            if (flush_i) begin
                wp_q  <= '0;
                rp_q  <= '0;
                cnt_q <= '0;
            end else begin
                if (do_push) wp_q <= (wp_q == LAST_IDX) ? '0 : wp_q + 1'b1;
                if (do_pop)  rp_q <= (rp_q == LAST_IDX) ? '0 : rp_q + 1'b1;
                unique case ({do_push, do_pop})
                    2'b10:   cnt_q <= cnt_q + 1'b1;
                    2'b01:   cnt_q <= cnt_q - 1'b1;
                    default: cnt_q <= cnt_q;
                endcase
            end
        end
    end
endmodule

// File: rtl/orbit_period_mon.sv
module orbit_period_mon #(
    parameter int CNT_W  = 32,
    parameter int PER_W  = 14,
    parameter int LAST_W = 12,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              orbit_i,
    input  logic              pcnt_en_i,
    input  logic              pcnt_clr_i,
    input  logic              per_en_i,
    input  logic              per_clr_i,
    input  logic              rd_req_i,
    output logic [PER_W+1:0]  rd_word_o,
    output logic [LAST_W-1:0] last_period_o,
    output logic [CNT_W-1:0]  pulse_count_o,
    output logic [1:0]        fifo_status_o
);
    logic             orbit_q;
    logic             orbit_edge;
    logic             push;
    logic [PER_W-1:0] period;
    logic             full, empty;

    always_ff @(posedge clk) begin
        if (!rst_n) orbit_q <= 1'b0;
        else        orbit_q <= orbit_i;
    end

    assign orbit_edge    = orbit_i && !orbit_q;
    assign fifo_status_o = {full, empty};

    opm_pulse_counter #(.CNT_W(CNT_W)) u_pcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_i   (orbit_edge),
        .enable_i (pcnt_en_i),
        .clear_i  (pcnt_clr_i),
        .count_o  (pulse_count_o)
    );

    opm_period_fsm #(.PER_W(PER_W), .LAST_W(LAST_W)) u_per (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_i    (orbit_edge),
        .enable_i  (per_en_i),
        .restart_i (per_clr_i),
        .push_o    (push),
        .period_o  (period),
        .last_o    (last_period_o)
    );

    opm_history_fifo #(.W(PER_W), .DEPTH(DEPTH)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push),
        .din_i     (period),
        .rd_i      (rd_req_i),
        .flush_i   (per_clr_i),
        .rd_word_o (rd_word_o),
        .full_o    (full),
        .empty_o   (empty)
    );
endmodule

// File: rtl/opm_checker.sv
module opm_checker #(
    parameter int CNT_W  = 32,
    parameter int PER_W  = 14,
    parameter int LAST_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              orbit_i,
    input logic              pcnt_en_i,
    input logic              pcnt_clr_i,
    input logic              per_en_i,
    input logic              per_clr_i,
    input logic              rd_req_i,
    input logic [PER_W+1:0]  rd_word_o,
    input logic [LAST_W-1:0] last_period_o,
    input logic [CNT_W-1:0]  pulse_count_o,
    input logic [1:0]        fifo_status_o
);
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_clr_i |=> (pulse_count_o == '0)); // R3

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pcnt_clr_i && !pcnt_en_i) |=> $stable(pulse_count_o)); // R2

    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_status_o != 2'b11); // R7

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        per_clr_i |=> (fifo_status_o == 2'b01)); // R9

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req_i |=> $stable(rd_word_o)); // R6

    AST_BIT15_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word_o[PER_W+1] == 1'b0); // R6

    AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_status_o[1] && !rd_req_i && !per_clr_i) |=> fifo_status_o[1]); // R8

    AST_OFF_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_en_i && !rd_req_i && !per_clr_i) |=>
            ($stable(fifo_status_o) && $stable(last_period_o))); // R10
endmodule

bind orbit_period_mon opm_checker #(
    .CNT_W(CNT_W), .PER_W(PER_W), .LAST_W(LAST_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .orbit_i       (orbit_i),
    .pcnt_en_i     (pcnt_en_i),
    .pcnt_clr_i    (pcnt_clr_i),
    .per_en_i      (per_en_i),
    .per_clr_i     (per_clr_i),
    .rd_req_i      (rd_req_i),
    .rd_word_o     (rd_word_o),
    .last_period_o (last_period_o),
    .pulse_count_o (pulse_count_o),
    .fifo_status_o (fifo_status_o)
);

// File: tb/orbit_period_mon_bench.sv
`timescale 1ns/1ps
module orbit_period_mon_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic orbit = 1'b0, pcnt_en = 1'b0, pcnt_clr = 1'b0;
    logic per_en = 1'b0, per_clr = 1'b0, rd_req = 1'b0;
    logic [15:0] rd_word;
    logic [11:0] last_period;
    logic [31:0] pulse_count;
    logic [1:0]  status;
    logic [3:0]  narrow_count;
    logic [15:0] n_rd;
    logic [11:0] n_last;
    logic [1:0]  n_status;

    int checks = 0;
    int failures = 0;
    int mism;

    localparam int NV = 8;
    localparam int GAPS [NV] = '{2, 3, 5, 9, 33, 100, 1000, 5000};

    always #2 clk = ~clk;

    orbit_period_mon u_orbit_period_mon (
        .clk(clk), .rst_n(rst_n), .orbit_i(orbit),
        .pcnt_en_i(pcnt_en), .pcnt_clr_i(pcnt_clr),
        .per_en_i(per_en), .per_clr_i(per_clr), .rd_req_i(rd_req),
        .rd_word_o(rd_word), .last_period_o(last_period),
        .pulse_count_o(pulse_count), .fifo_status_o(status)
    );

    orbit_period_mon #(.CNT_W(4), .DEPTH(4)) u_narrow (
        .clk(clk), .rst_n(rst_n), .orbit_i(orbit),
        .pcnt_en_i(pcnt_en), .pcnt_clr_i(pcnt_clr),
        .per_en_i(per_en), .per_clr_i(per_clr), .rd_req_i(rd_req),
        .rd_word_o(n_rd), .last_period_o(n_last),
        .pulse_count_o(narrow_count), .fifo_status_o(n_status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    // edge lands exactly g rising edges after the previous edge/event
    task automatic gap_pulse(input int g);
        orbit = 1'b0;
        repeat (g - 1) cyc();
        orbit = 1'b1;
        cyc();
        orbit = 1'b0;
    endtask

    task automatic read_word();
        rd_req = 1'b1;
        cyc();
        rd_req = 1'b0;
    endtask

    initial begin
        #(4 * 190000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        chk("R1 count", pulse_count, 0);
        chk("R1 last", last_period, 0);
        chk("R1 status", {30'd0, status}, 2'b01);
        chk("R1 rdword", {16'd0, rd_word}, 0);
        read_word();
        chk("R6 empty read", {16'd0, rd_word}, 32'h4000);

        // vector table walk
        per_en = 1'b1;
        pcnt_en = 1'b1;
        cyc();
        for (int i = 0; i < NV; i++) begin
            gap_pulse(GAPS[i]);
            chk("R5 last period", {20'd0, last_period}, (GAPS[i] + 1) & 32'hFFF);
        end
        chk("R2 count", pulse_count, NV);
        chk("R7 not empty", {30'd0, status}, 2'b00);
        for (int i = 0; i < NV; i++) begin
            read_word();
            chk("R6 history word", {16'd0, rd_word},
                ((i == NV - 1) ? 32'h4000 : 32'h0) | (GAPS[i] + 1));
        end
        read_word();
        chk("R6 drained", {16'd0, rd_word}, 32'h4000);
        chk("R7 empty", {30'd0, status}, 2'b01);

        // pulse counter details
        pcnt_clr = 1'b1; cyc(); pcnt_clr = 1'b0;
        chk("R3 clear", pulse_count, 0);
        orbit = 1'b1; repeat (3) cyc(); orbit = 1'b0; cyc();
        chk("R2 long pulse once", pulse_count, 1);
        orbit = 1'b1; pcnt_clr = 1'b1; cyc(); pcnt_clr = 1'b0; orbit = 1'b0;
        chk("R3 clear beats edge", pulse_count, 0);
        pcnt_en = 1'b0;
        gap_pulse(4);
        cyc();
        chk("R2 disabled hold", pulse_count, 0);
        pcnt_en = 1'b1;

        // period clear with simultaneous edge
        per_clr = 1'b1; orbit = 1'b1; cyc(); per_clr = 1'b0; orbit = 1'b0;
        chk("R9 flushed", {30'd0, status}, 2'b01);
        gap_pulse(6);
        chk("R9 timed from clear", {20'd0, last_period}, 7);
        read_word();
        chk("R9 only one entry", {16'd0, rd_word}, 32'h4007);

        // disabled measurement
        per_en = 1'b0; cyc();
        gap_pulse(5); gap_pulse(5); cyc();
        chk("R10 no store", {30'd0, status}, 2'b01);
        chk("R10 last held", {20'd0, last_period}, 7);
        per_en = 1'b1; cyc();
        gap_pulse(12);
        chk("R10 timed from arm", {20'd0, last_period}, 13);
        read_word();
        chk("R10 stored", {16'd0, rd_word}, 32'h400D);

        // history full and drop
        per_clr = 1'b1; cyc(); per_clr = 1'b0;
        for (int i = 0; i < 256; i++) gap_pulse(2);
        chk("R7 full", {30'd0, status}, 2'b10);
        gap_pulse(4);
        chk("R8 last still updates", {20'd0, last_period}, 5);
        chk("R8 still full", {30'd0, status}, 2'b10);
        mism = 0;
        for (int i = 0; i < 256; i++) begin
            read_word();
            if (rd_word !== ((i == 255) ? 16'h4003 : 16'h0003)) mism++;
        end
        chk("R8 entries unchanged", mism, 0);
        chk("R8 last entry flag", {16'd0, rd_word}, 32'h4003);
        chk("R7 empty after drain", {30'd0, status}, 2'b01);

        // saturation
        per_clr = 1'b1; cyc(); per_clr = 1'b0;
        gap_pulse(20000);
        chk("R11 last saturated", {20'd0, last_period}, 32'hFFF);
        read_word();
        chk("R11 word saturated", {16'd0, rd_word}, 32'h7FFF);

        // wrap on a narrow counter
        pcnt_clr = 1'b1; cyc(); pcnt_clr = 1'b0;
        for (int i = 0; i < 16; i++) gap_pulse(2);
        chk("R4 wrap to zero", {28'd0, narrow_count}, 0);
        chk("R4 wide count", pulse_count, 16);
        gap_pulse(2);
        chk("R4 after wrap", {28'd0, narrow_count}, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule